// File: doc/BRIEF.md
# Audio Serial Clock Generator

This block derives the timing for a stereo or multi-slot serial audio link from one fast reference clock. It makes a master clock, a bit clock and a frame strobe. The frame strobe is a word select for two-channel framing or a one-bit frame pulse for time-division framing. The master clock rate is a programmable multiple of the sample rate, from 16 to 1024 times fs. That multiple is the product of the bit-clock divider, the slot count and the slot width.

The block has three roles. As **master** it drives all clocks and permits data transfer. As **clock-only controller** it drives the same clocks but holds the data-transfer permit low. As **slave** it follows an external bit clock, or an external master clock from which it divides its own bit clock, and still produces the frame strobe as a timing reference. Configuration is written through a write strobe. A write that the block accepts is held pending. It goes live at once while the block is disabled, and only at the next frame boundary while it runs, so a running clock never shows a shortened pulse.

All inputs and outputs are sampled in the reference clock domain. External clocks are expected to arrive already synchronized.

Top module: `audio_clkgen`

## Requirements
- R1: The number of master-clock periods per frame equals bdiv × slots × width (the master-clock-to-fs ratio). In master and controller roles it is observable as master-clock rising edges between successive rising edges of the frame strobe.
- R2: A configuration write is rejected and leaves the pending setting unchanged when any of these holds: the ratio lies outside 16..1024; slots is outside 1..8; width is outside 8..32; bdiv or mhalf is zero; or the role code is 3.
- R3: In master and controller roles the master clock toggles every mhalf reference cycles. The bit clock toggles on every bdiv-th master-clock toggle and starts low after enable.
- R4: In word-select framing (tdm=0), which requires slots=2 or the write is rejected, the strobe is low for the left slot and high for the right slot. It changes one bit period before each slot's first bit.
- R5: In TDM framing (tdm=1), the strobe is high for exactly the last bit period of the frame, just before slot 0.
- R6: Slave role with source code 0: every falling edge of ext_bck_i advances the bit position. mck_o, bck_o, mck_oe_o and bck_oe_o stay 0, and the strobe is still produced.
- R7: Slave role with source code 1: every edge of ext_mck_i counts as a master-clock toggle, from which the bit clock is divided and driven (bck_oe_o=1). mck_oe_o stays 0.
- R8: Role codes are 0 master, 1 slave and 2 clock-only. xfer_en_o is 1 when enabled in the master or slave role and 0 in the clock-only role.
- R9: While enabled, an accepted write takes effect only when the last bit of the current frame ends. While disabled, it is live two cycles after the write.
- R10: While enabled, a write that changes the role or the slave source is rejected.
- R11: With en_i low, all outputs are 0 in the same cycle, and clocks and bit position restart from zero on re-enable.
- R12: After reset the setting is master, word-select framing, slots 2, width 16, bdiv 4, mhalf 2 (ratio 128), and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_i | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Clock unit enable |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_role_i | input | 2 | Role: 0 master, 1 slave, 2 clock-only |
| cfg_src_i | input | 1 | Slave source: 0 external bit clock, 1 external master clock |
| cfg_tdm_i | input | 1 | 0 word-select framing, 1 TDM framing |
| cfg_slots_i | input | 4 | Slots per frame |
| cfg_width_i | input | 6 | Bits per slot |
| cfg_bdiv_i | input | 8 | Master-clock periods per bit-clock period |
| cfg_mhalf_i | input | 8 | Reference cycles per master-clock half period |
| ext_bck_i | input | 1 | External bit clock (synchronized) |
| ext_mck_i | input | 1 | External master clock (synchronized) |
| mck_o | output | 1 | Master clock |
| bck_o | output | 1 | Bit clock |
| fs_o | output | 1 | Word select or frame sync |
| mck_oe_o | output | 1 | Master clock is driven |
| bck_oe_o | output | 1 | Bit clock is driven |
| xfer_en_o | output | 1 | Data transfer permitted |

## Verification
A wrong divider count appears on mck_o or bck_o at the very next expected toggle, which is at most mhalf reference cycles away. A wrong bit position or a wrongly loaded setting appears on fs_o by the next strobe transition, which is never more than one frame later. The frame-ratio measurement catches a misapplied setting within two frames. A configuration applied too early appears as a strobe edge in the middle of the old frame.

// File: rtl/aclk_pkg.sv
package aclk_pkg;

    localparam int MAX_SLOTS = 8;
    localparam int MIN_WIDTH = 8;
    localparam int MAX_WIDTH = 32;
    localparam int MIN_RATIO = 16;
    localparam int MAX_RATIO = 1024;
    localparam int SLOTS_W   = $clog2(MAX_SLOTS + 1);
    localparam int WIDTH_W   = $clog2(MAX_WIDTH + 1);
    localparam int DIV_W     = 8;
    localparam int LEN_W     = $clog2(MAX_SLOTS * MAX_WIDTH + 1);

    typedef enum logic [1:0] {
        ROLE_MASTER  = 2'd0,
        ROLE_SLAVE   = 2'd1,
        ROLE_CLKONLY = 2'd2,
        ROLE_RSVD    = 2'd3
    } role_e;

    typedef struct packed {
        role_e              role;
        logic               src_mck;
        logic               tdm;
        logic [SLOTS_W-1:0] slots;
        logic [WIDTH_W-1:0] width;
        logic [DIV_W-1:0]   bdiv;
        logic [DIV_W-1:0]   mhalf;
    } clk_cfg_t;

    localparam clk_cfg_t CFG_RESET = '{
        role:    ROLE_MASTER,
        src_mck: 1'b0,
        tdm:     1'b0,
        slots:   SLOTS_W'(2),
        width:   WIDTH_W'(16),
        bdiv:    DIV_W'(4),
        mhalf:   DIV_W'(2)
    };

    function automatic int unsigned mck_ratio(clk_cfg_t c);
        return 32'(c.bdiv) * 32'(c.slots) * 32'(c.width);
    endfunction

    function automatic logic [LEN_W-1:0] frame_len(clk_cfg_t c);
        return LEN_W'(32'(c.slots) * 32'(c.width));
    endfunction

    function automatic logic cfg_ok(clk_cfg_t nw, clk_cfg_t cur, logic running);
        int unsigned r;
        logic        fields_ok;
        logic        lock_ok;
        r = mck_ratio(nw);
        fields_ok = (nw.role != ROLE_RSVD)
                 && (nw.slots != '0) && (32'(nw.slots) <= MAX_SLOTS)
                 && (32'(nw.width) >= MIN_WIDTH) && (32'(nw.width) <= MAX_WIDTH)
                 && (nw.bdiv != '0) && (nw.mhalf != '0)
                 && (r >= MIN_RATIO) && (r <= MAX_RATIO)
                 && (nw.tdm || (32'(nw.slots) == 2));
        lock_ok = !running || ((nw.role == cur.role) && (nw.src_mck == cur.src_mck));
        return fields_ok && lock_ok;
    endfunction

    // Strobe level for a given bit position in the frame.
    function automatic logic frame_strobe(logic [LEN_W-1:0] pos, clk_cfg_t c);
        logic [LEN_W-1:0] last;
        logic [LEN_W-1:0] nxt;
        last = frame_len(c) - LEN_W'(1);
        nxt  = (pos == last) ? '0 : pos + LEN_W'(1);
        if (c.tdm)
            return pos == last;
        return nxt >= LEN_W'(c.width);
    endfunction

endpackage

// File: rtl/aclk_cfg_regs.sv
module aclk_cfg_regs
    import aclk_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_i,
    input  logic     en_i,
    input  logic     wr_i,
    input  clk_cfg_t wr_cfg_i,
    input  logic     frame_wrap_i,
    output clk_cfg_t pend_o,
    output clk_cfg_t act_o
);

    clk_cfg_t pend_q;
    clk_cfg_t act_q;
    logic     accept;

    assign accept = wr_i && cfg_ok(wr_cfg_i, pend_q, en_i);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pend_q <= CFG_RESET;
            act_q  <= CFG_RESET;
        end else begin
            if (accept)
                pend_q <= wr_cfg_i;
            if (!en_i || frame_wrap_i)
                act_q <= pend_q;
        end
    end

    assign pend_o = pend_q;
    assign act_o  = act_q;

    // R2: the live setting is always inside the legal ratio window
    a_r2_ratio_legal: assert property (@(posedge clk_i) disable iff (rst_i)
        (mck_ratio(act_q) >= MIN_RATIO) && (mck_ratio(act_q) <= MAX_RATIO));

    // R9: while running, the live setting moves only at a frame boundary
    a_r9_load_at_wrap: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(en_i) && !$stable(act_q) |-> $past(frame_wrap_i));

    // R10: role and slave source cannot be changed while running
    a_r10_role_locked: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(en_i) |-> (pend_q.role == $past(pend_q.role))
                     && (pend_q.src_mck == $past(pend_q.src_mck)));

endmodule

// File: rtl/aclk_divider.sv
module aclk_divider
    import aclk_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             en_i,
    input  clk_cfg_t         act_i,
    input  logic             ext_bck_i,
    input  logic             ext_mck_i,
    output logic             mck_o,
    output logic             bck_o,
    output logic             bit_adv_o
);

    logic [DIV_W-1:0] mcnt_q;
    logic [DIV_W-1:0] bcnt_q;
    logic             mck_q;
    logic             bck_q;
    logic             ebck_q;
    logic             emck_q;
    logic             slave_bck;
    logic             slave_mck;
    logic             mck_tick;
    logic             bck_tick;

    assign slave_bck = (act_i.role == ROLE_SLAVE) && !act_i.src_mck;
    assign slave_mck = (act_i.role == ROLE_SLAVE) &&  act_i.src_mck;

    always_comb begin
        if (slave_mck)
            mck_tick = ext_mck_i ^ emck_q;
        else
            mck_tick = (mcnt_q == act_i.mhalf - DIV_W'(1));
        bck_tick = mck_tick && (bcnt_q == act_i.bdiv - DIV_W'(1));
        if (!en_i)
            bit_adv_o = 1'b0;
        else if (slave_bck)
            bit_adv_o = ebck_q && !ext_bck_i;
        else
            bit_adv_o = bck_tick && bck_q;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            mcnt_q <= '0;
            bcnt_q <= '0;
            mck_q  <= 1'b0;
            bck_q  <= 1'b0;
            ebck_q <= 1'b0;
            emck_q <= 1'b0;
        end else begin
            ebck_q <= ext_bck_i;
            emck_q <= ext_mck_i;
            if (!en_i) begin
                mcnt_q <= '0;
                bcnt_q <= '0;
                mck_q  <= 1'b0;
                bck_q  <= 1'b0;
            end else if (slave_bck) begin
                bck_q  <= ext_bck_i;
            end else begin
                if (!slave_mck)
                    mcnt_q <= mck_tick ? '0 : mcnt_q + DIV_W'(1);
                if (mck_tick) begin
                    mck_q <= !mck_q;
                    if (bck_tick) begin
                        bcnt_q <= '0;
                        bck_q  <= !bck_q;
                    end else begin
                        bcnt_q <= bcnt_q + DIV_W'(1);
                    end
                end
            end
        end
    end

    assign mck_o = mck_q;
    assign bck_o = bck_q;

    // R3: half-period counter never passes its programmed limit
    a_r3_mcnt_bound: assert property (@(posedge clk_i) disable iff (rst_i)
        en_i && !slave_mck && !slave_bck |-> mcnt_q < act_i.mhalf);

    // R3: a generated bit-clock edge always coincides with a master-clock edge
    a_r3_bck_on_mck_edge: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(en_i) && !$past(slave_bck) && !$stable(bck_q) |-> !$stable(mck_q));

    // R6: an external bit clock run keeps the master clock idle
    a_r6_slave_mck_idle: assert property (@(posedge clk_i) disable iff (rst_i)
        slave_bck |-> !mck_q);

endmodule

// File: rtl/aclk_framer.sv
module aclk_framer
    import aclk_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             en_i,
    input  logic             bit_adv_i,
    input  clk_cfg_t         act_i,
    output logic             wrap_o,
    output logic             strobe_o
);

    logic [LEN_W-1:0] pos_q;
    logic [LEN_W-1:0] last;

    assign last     = frame_len(act_i) - LEN_W'(1);
    assign wrap_o   = bit_adv_i && (pos_q == last);
    assign strobe_o = frame_strobe(pos_q, act_i);

    always_ff @(posedge clk_i) begin
        if (rst_i || !en_i)
            pos_q <= '0;
        else if (bit_adv_i)
            pos_q <= wrap_o ? '0 : pos_q + LEN_W'(1);
    end

    // R5: position stays inside the live frame
    a_r5_pos_in_frame: assert property (@(posedge clk_i) disable iff (rst_i)
        pos_q <= last);

    // R4: the strobe level only moves when a bit period ends
    a_r4_strobe_on_bit: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(en_i) && en_i && !$stable(strobe_o) |-> $past(bit_adv_i));

endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen
    import aclk_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               en_i,
    input  logic               cfg_wr_i,
    input  logic [1:0]         cfg_role_i,
    input  logic               cfg_src_i,
    input  logic               cfg_tdm_i,
    input  logic [3:0]         cfg_slots_i,
    input  logic [5:0]         cfg_width_i,
    input  logic [7:0]         cfg_bdiv_i,
    input  logic [7:0]         cfg_mhalf_i,
    input  logic               ext_bck_i,
    input  logic               ext_mck_i,
    output logic               mck_o,
    output logic               bck_o,
    output logic               fs_o,
    output logic               mck_oe_o,
    output logic               bck_oe_o,
    output logic               xfer_en_o
);

    clk_cfg_t wr_cfg;
    clk_cfg_t pend;
    clk_cfg_t act;
    logic     wrap;
    logic     bit_adv;
    logic     mck_raw;
    logic     bck_raw;
    logic     strobe;

    always_comb begin
        wr_cfg.role    = role_e'(cfg_role_i);
        wr_cfg.src_mck = cfg_src_i;
        wr_cfg.tdm     = cfg_tdm_i;
        wr_cfg.slots   = SLOTS_W'(cfg_slots_i);
        wr_cfg.width   = WIDTH_W'(cfg_width_i);
        wr_cfg.bdiv    = DIV_W'(cfg_bdiv_i);
        wr_cfg.mhalf   = DIV_W'(cfg_mhalf_i);
    end

    aclk_cfg_regs i_cfg (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .en_i         (en_i),
        .wr_i         (cfg_wr_i),
        .wr_cfg_i     (wr_cfg),
        .frame_wrap_i (wrap),
        .pend_o       (pend),
        .act_o        (act)
    );

    aclk_divider i_div (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .en_i      (en_i),
        .act_i     (act),
        .ext_bck_i (ext_bck_i),
        .ext_mck_i (ext_mck_i),
        .mck_o     (mck_raw),
        .bck_o     (bck_raw),
        .bit_adv_o (bit_adv)
    );

    aclk_framer i_frm (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .en_i      (en_i),
        .bit_adv_i (bit_adv),
        .act_i     (act),
        .wrap_o    (wrap),
        .strobe_o  (strobe)
    );

    assign mck_oe_o  = en_i && (act.role != ROLE_SLAVE);
    assign bck_oe_o  = en_i && !((act.role == ROLE_SLAVE) && !act.src_mck);
    assign xfer_en_o = en_i && (act.role != ROLE_CLKONLY);
    assign mck_o     = mck_oe_o && mck_raw;
    assign bck_o     = bck_oe_o && bck_raw;
    assign fs_o      = en_i && strobe;

    // R8: clock-only role never permits data transfer
    a_r8_clkonly_no_xfer: assert property (@(posedge clk_i) disable iff (rst_i)
        (pend.role == ROLE_CLKONLY) && $past(en_i) && en_i && (act.role == pend.role)
        |-> !xfer_en_o && mck_oe_o);

endmodule

// File: tb/test_audio_clkgen.sv
module test_audio_clkgen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic       wr = 1'b0;
    logic [1:0] w_role = '0;
    logic       w_src = 1'b0;
    logic       w_tdm = 1'b0;
    logic [3:0] w_slots = '0;
    logic [5:0] w_width = '0;
    logic [7:0] w_bdiv = '0;
    logic [7:0] w_mhalf = '0;
    logic       ext_bck = 1'b0;
    logic       ext_mck = 1'b0;
    logic       mck_o, bck_o, fs_o, mck_oe_o, bck_oe_o, xfer_en_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #4 clk = !clk;

    audio_clkgen i_audio_clkgen (
        .clk_i(clk), .rst_i(rst), .en_i(en), .cfg_wr_i(wr),
        .cfg_role_i(w_role), .cfg_src_i(w_src), .cfg_tdm_i(w_tdm),
        .cfg_slots_i(w_slots), .cfg_width_i(w_width), .cfg_bdiv_i(w_bdiv),
        .cfg_mhalf_i(w_mhalf), .ext_bck_i(ext_bck), .ext_mck_i(ext_mck),
        .mck_o(mck_o), .bck_o(bck_o), .fs_o(fs_o), .mck_oe_o(mck_oe_o),
        .bck_oe_o(bck_oe_o), .xfer_en_o(xfer_en_o)
    );

    // behavioural reference state: pending (p), live (a), timing (m)
    int p_role, p_src, p_tdm, p_slots, p_width, p_bdiv, p_mhalf;
    int a_role, a_src, a_tdm, a_slots, a_width, a_bdiv, a_mhalf;
    int m_mcnt, m_bcnt, m_mck, m_bck, m_bit, m_eb, m_em;

    function automatic bit legal(int role, int src, int tdm, int slots, int width,
                                 int bdiv, int mhalf, bit running);
        int r;
        r = bdiv * slots * width;
        if (role == 3 || slots < 1 || slots > 8 || width < 8 || width > 32) return 0;
        if (bdiv == 0 || mhalf == 0 || r < 16 || r > 1024) return 0;
        if (tdm == 0 && slots != 2) return 0;
        if (running && (role != p_role || src != p_src)) return 0;
        return 1;
    endfunction

    function automatic bit exp_strobe();
        int n;
        n = a_slots * a_width;
        if (a_tdm != 0) return m_bit == n - 1;
        return ((m_bit + 1) % n) >= a_width;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            p_role = 0; p_src = 0; p_tdm = 0; p_slots = 2; p_width = 16; p_bdiv = 4; p_mhalf = 2;
            a_role = 0; a_src = 0; a_tdm = 0; a_slots = 2; a_width = 16; a_bdiv = 4; a_mhalf = 2;
            m_mcnt = 0; m_bcnt = 0; m_mck = 0; m_bck = 0; m_bit = 0; m_eb = 0; m_em = 0;
        end else begin
            int o_role, o_src, o_tdm, o_slots, o_width, o_bdiv, o_mhalf;
            bit sb, sm, mt, adv;
            o_role = p_role; o_src = p_src; o_tdm = p_tdm; o_slots = p_slots;
            o_width = p_width; o_bdiv = p_bdiv; o_mhalf = p_mhalf;
            sb = (a_role == 1 && a_src == 0);
            sm = (a_role == 1 && a_src == 1);
            mt = sm ? (int'(ext_mck) != m_em) : (m_mcnt == a_mhalf - 1);
            if (sb) adv = (m_eb == 1 && ext_bck == 0);
            else    adv = mt && (m_bcnt == a_bdiv - 1) && (m_bck == 1);
            if (wr && legal(w_role, w_src, w_tdm, w_slots, w_width, w_bdiv, w_mhalf, en)) begin
                p_role = w_role; p_src = w_src; p_tdm = w_tdm; p_slots = w_slots;
                p_width = w_width; p_bdiv = w_bdiv; p_mhalf = w_mhalf;
            end
            if (!en) begin
                m_mcnt = 0; m_bcnt = 0; m_mck = 0; m_bck = 0; m_bit = 0;
                a_role = o_role; a_src = o_src; a_tdm = o_tdm; a_slots = o_slots;
                a_width = o_width; a_bdiv = o_bdiv; a_mhalf = o_mhalf;
            end else begin
                if (sb) m_bck = ext_bck;
                else begin
                    if (!sm) m_mcnt = mt ? 0 : m_mcnt + 1;
                    if (mt) begin
                        m_mck = 1 - m_mck;
                        if (m_bcnt == a_bdiv - 1) begin m_bcnt = 0; m_bck = 1 - m_bck; end
                        else m_bcnt = m_bcnt + 1;
                    end
                end
                if (adv) begin
                    if (m_bit == a_slots * a_width - 1) begin
                        m_bit = 0;
                        a_role = o_role; a_src = o_src; a_tdm = o_tdm; a_slots = o_slots;
                        a_width = o_width; a_bdiv = o_bdiv; a_mhalf = o_mhalf;
                    end else m_bit = m_bit + 1;
                end
            end
            m_eb = ext_bck; m_em = ext_mck;
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // per-cycle comparison against the reference, away from the clock edge
    always @(negedge clk) begin
        if (!rst) begin
            bit sb;
            sb = (a_role == 1 && a_src == 0);
            chk("R3 mck_o", mck_o, en && a_role != 1 && m_mck == 1);
            chk("R3 R7 bck_o", bck_o, en && !sb && m_bck == 1);
            chk(a_tdm != 0 ? "R5 R9 fs_o" : "R4 R9 fs_o", fs_o, en && exp_strobe());
            chk("R6 mck_oe_o", mck_oe_o, en && a_role != 1);
            chk("R6 bck_oe_o", bck_oe_o, en && !sb);
            chk("R8 xfer_en_o", xfer_en_o, en && a_role != 2);
        end
    end

    // frame ratio and edge counters observed at the ports
    int mck_rises = 0, last_ratio = 0, fs_rises = 0, bck_rises = 0;
    logic pm = 1'b0, pf = 1'b0, pb = 1'b0;
    always @(negedge clk) begin
        if (mck_o && !pm) mck_rises++;
        if (bck_o && !pb) bck_rises++;
        if (fs_o && !pf) begin fs_rises++; last_ratio = mck_rises; mck_rises = 0; end
        pm = mck_o; pf = fs_o; pb = bck_o;
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
            summary();
        end
    end

    task automatic wait_cyc(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic write_cfg(int role, int src, int tdm, int slots, int width,
                             int bdiv, int mhalf);
        @(posedge clk); #1;
        w_role = 2'(role); w_src = 1'(src); w_tdm = 1'(tdm); w_slots = 4'(slots);
        w_width = 6'(width); w_bdiv = 8'(bdiv); w_mhalf = 8'(mhalf); wr = 1'b1;
        @(posedge clk); #1;
        wr = 1'b0;
    endtask

    task automatic set_en(bit v);
        @(posedge clk); #1;
        en = v;
    endtask

    initial begin
        wait_cyc(5);
        rst = 1'b0;
        @(negedge clk);
        // R12: reset state
        chk("R12 mck_o", mck_o, 0);
        chk("R12 fs_o", fs_o, 0);
        chk("R12 xfer_en_o", xfer_en_o, 0);

        // R1 R3 R4: default master, word select, ratio 128
        set_en(1);
        @(negedge clk);
        chk("R8 master xfer", xfer_en_o, 1);
        wait_cyc(1600);
        chk("R1 default ratio", last_ratio, 128);

        // R9: TDM 4x8, bdiv 1, mhalf 1 written while running
        write_cfg(0, 0, 1, 4, 8, 1, 1);
        wait_cyc(20);
        chk("R9 old frame kept", last_ratio, 128);
        wait_cyc(1200);
        chk("R1 R5 tdm ratio", last_ratio, 32);

        // R2: illegal ratios, R4: word select with 4 slots, R10: role change
        write_cfg(0, 0, 1, 8, 32, 8, 1);
        write_cfg(0, 0, 1, 1, 8, 1, 1);
        write_cfg(0, 0, 0, 4, 8, 1, 1);
        write_cfg(0, 0, 1, 2, 8, 1, 0);
        write_cfg(3, 0, 1, 4, 8, 1, 1);
        write_cfg(2, 0, 1, 2, 16, 1, 1);
        wait_cyc(400);
        chk("R2 R10 rejected writes", last_ratio, 32);
        chk("R10 role kept", xfer_en_o, 1);

        // R11: disable clears outputs in the same cycle
        set_en(0);
        @(negedge clk);
        chk("R11 mck_o off", mck_o, 0);
        chk("R11 bck_o off", bck_o, 0);
        chk("R11 fs_o off", fs_o, 0);

        // R8: clock-only role, word select, ratio 64
        write_cfg(2, 0, 0, 2, 16, 2, 1);
        wait_cyc(3);
        set_en(1);
        @(negedge clk);
        chk("R8 clkonly xfer", xfer_en_o, 0);
        chk("R8 clkonly mck_oe", mck_oe_o, 1);
        wait_cyc(600);
        chk("R1 R8 clkonly ratio", last_ratio, 64);

        // R6: slave from external bit clock, TDM 2x8
        set_en(0);
        write_cfg(1, 0, 1, 2, 8, 1, 1);
        wait_cyc(3);
        set_en(1);
        wait_cyc(2);
        fs_rises = 0;
        for (int i = 0; i < 80; i++) begin
            wait_cyc(3);
            ext_bck = !ext_bck;
        end
        wait_cyc(3);
        chk("R6 slave mck_oe", mck_oe_o, 0);
        chk("R6 slave bck_oe", bck_oe_o, 0);
        chk("R6 slave frame strobes", fs_rises, 2);

        // R7: slave from external master clock, TDM 1x16, bdiv 1
        set_en(0);
        write_cfg(1, 1, 1, 1, 16, 1, 1);
        wait_cyc(3);
        set_en(1);
        wait_cyc(2);
        bck_rises = 0;
        for (int i = 0; i < 200; i++) begin
            wait_cyc(2);
            ext_mck = !ext_mck;
        end
        wait_cyc(3);
        chk("R7 slave mck_oe", mck_oe_o, 0);
        chk("R7 slave bck_oe", bck_oe_o, 1);
        chk("R7 bck from ext mck", bck_rises, 100);

        // R12: reset restores defaults
        rst = 1'b1;
        en = 1'b0;
        wait_cyc(3);
        rst = 1'b0;
        set_en(1);
        wait_cyc(1600);
        chk("R12 R1 ratio after reset", last_ratio, 128);

        summary();
    end

endmodule